// File: doc/BRIEF.md
# Multi-Domain Clock Ratio Generator

This block takes one fast reference clock, which stands for a multiplied-up oscillator, and divides it for four related domains: core, bus, peripheral and timer. For each domain it produces a clock-enable strobe. A strobe is one reference cycle wide and repeats every 2, 4 or 8 reference cycles. A single free-running 3-bit phase counter drives all four strobes, so they stay phase-locked to each other. Every strobe fires on the cycle where the counter wraps.

Software programs the ratios with one write port. The port carries four 2-bit ratio fields and an error-clear bit. Each write is checked against fixed relations between the domains. A legal write is held as pending and takes effect on the next counter wrap, with all four fields applied together. An illegal write is dropped and sets a sticky error flag. A clock-out enable for an external pin follows the bus strobe.

Top module: `clk_ratio_gen`

## Requirements
- R1: After reset, `active_cfg` reads 8'hAA (every domain at /8), `err_flag` is 0, and no strobe is high while reset is held.
- R2: A field code of 2'b00 makes its strobe pulse every 2nd cycle, 2'b01 every 4th cycle and 2'b10 every 8th cycle. Each pulse is one cycle wide. Taking the phase p as the number of clock edges since reset released, modulo 8, a /N strobe is high when (p+1) is a multiple of N.
- R3: On the phase-7 cycle, all four strobes are high together.
- R4: The `wr_data` field positions are core [1:0], bus [3:2], peripheral [5:4] and timer [7:6]. A write whose bus code differs from its peripheral code is refused.
- R5: A write whose timer code is numerically greater than its peripheral code (a slower timer) is refused.
- R6: A write whose core code is numerically greater than its bus code (a slower core) is refused.
- R7: A write that holds the reserved code 2'b11 in any field is refused, even if every relation between the domains holds.
- R8: A refused write leaves `active_cfg` unchanged and sets `err_flag`. The flag stays set through later legal writes.
- R9: A write with `wr_data[8]` = 1 clears `err_flag`. If that same write is refused, the flag is set instead.
- R10: An accepted write does not change `active_cfg` before the next phase-7 cycle. It shows in `active_cfg` and in the strobes from the following cycle on.
- R11: `ckout_en` equals `bus_stb` on every cycle.
- R12: A second accepted write made before the pending one is applied replaces it. Only the later value reaches `active_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the ratio register |
| wr_data | input | 9 | Ratio fields [7:0]; bit 8 clears the error flag |
| core_stb | output | 1 | Core-domain clock enable |
| bus_stb | output | 1 | Bus-domain clock enable |
| per_stb | output | 1 | Peripheral-domain clock enable |
| tmr_stb | output | 1 | Timer-domain clock enable |
| ckout_en | output | 1 | External clock-out enable, follows the bus strobe |
| active_cfg | output | 8 | Ratio setting currently in force |
| err_flag | output | 1 | Sticky flag for a refused write |

## Verification
The bench writes each illegal case in a form where only one rule breaks: the reserved code is tried with bus and peripheral matching and the timer at full speed. A checker that merged the reserved test into an ordering test would therefore pass that write. Writes are issued at whatever phase they happen to land on, including just before and just after the wrap. This catches a design that applies a change one frame early or late, which would show as an `active_cfg` change at the wrong cycle or as strobes that are misaligned for a frame. The sticky flag is tested for clear-and-fail in the same write, where set must win, and for a legal write without the clear bit, which must leave the flag set. Two back-to-back legal writes inside one frame check that the pending value is overwritten rather than queued.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;
  localparam int NUM_DOM = 4;
  localparam int FLD_W   = 2;
  localparam int CFG_W   = NUM_DOM * FLD_W;
  localparam int PH_W    = 3;

  localparam int D_CORE = 0;
  localparam int D_BUS  = 1;
  localparam int D_PER  = 2;
  localparam int D_TMR  = 3;

  typedef enum logic [FLD_W-1:0] {
    DIV2    = 2'b00,
    DIV4    = 2'b01,
    DIV8    = 2'b10,
    DIV_RSV = 2'b11
  } div_code_e;

  localparam logic [CFG_W-1:0] CFG_RESET = {NUM_DOM{DIV8}};

  function automatic logic [FLD_W-1:0] fld(input logic [CFG_W-1:0] cfg, input int idx);
    return cfg[idx*FLD_W +: FLD_W];
  endfunction

  // Smaller code means a faster domain.
  function automatic logic cfg_legal(input logic [CFG_W-1:0] cfg);
    logic ok;
    ok = 1'b1;
    for (int d = 0; d < NUM_DOM; d++)
      if (fld(cfg, d) == DIV_RSV) ok = 1'b0;
    if (fld(cfg, D_BUS) != fld(cfg, D_PER)) ok = 1'b0;
    if (fld(cfg, D_TMR) >  fld(cfg, D_PER)) ok = 1'b0;
    if (fld(cfg, D_CORE) > fld(cfg, D_BUS)) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic phase_hit(input logic [FLD_W-1:0] code, input logic [PH_W-1:0] ph);
    case (code)
      DIV2:    return ph[0];
      DIV4:    return &ph[1:0];
      DIV8:    return &ph;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/ratio_phase_ctr.sv
module ratio_phase_ctr
  import clk_ratio_pkg::*;
#(
  parameter int W = PH_W
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] phase,
  output logic         wrap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase + 1'b1;
  end

  assign wrap = &phase;
endmodule

// File: rtl/ratio_cfg_ctrl.sv
module ratio_cfg_ctrl
  import clk_ratio_pkg::*;
#(
  parameter int W = CFG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_cfg,
  input  logic         wr_clr_bit,
  input  logic         wrap,
  output logic [W-1:0] active_cfg,
  output logic         err_flag,
  output logic         pend_valid,
  output logic         wr_ok,
  output logic         wr_bad,
  output logic         wr_clr
);
  logic [W-1:0] pend_cfg;
  logic         legal;

  assign legal  = cfg_legal(wr_cfg);
  assign wr_ok  = wr_en &  legal;
  assign wr_bad = wr_en & ~legal;
  assign wr_clr = wr_en &  wr_clr_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_cfg <= CFG_RESET;
      pend_cfg   <= CFG_RESET;
      pend_valid <= 1'b0;
      err_flag   <= 1'b0;
    end else begin
      if (wrap && pend_valid) begin
        active_cfg <= pend_cfg;
        pend_valid <= 1'b0;
      end
      if (wr_ok) begin
        pend_cfg   <= wr_cfg;
        pend_valid <= 1'b1;
      end
      if (wr_bad)      err_flag <= 1'b1;
      else if (wr_clr) err_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/ratio_strobe_gen.sv
module ratio_strobe_gen
  import clk_ratio_pkg::*;
#(
  parameter int N = NUM_DOM
) (
  input  logic [PH_W-1:0]    phase,
  input  logic [N*FLD_W-1:0] cfg,
  output logic [N-1:0]       stb
);
  for (genvar d = 0; d < N; d++) begin : g_dom
    assign stb[d] = phase_hit(cfg[d*FLD_W +: FLD_W], phase);
  end
endmodule

// File: rtl/clk_ratio_gen.sv
module clk_ratio_gen
  import clk_ratio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W:0]   wr_data,
  output logic             core_stb,
  output logic             bus_stb,
  output logic             per_stb,
  output logic             tmr_stb,
  output logic             ckout_en,
  output logic [CFG_W-1:0] active_cfg,
  output logic             err_flag
);
  localparam int CLR_BIT = CFG_W;

  logic [PH_W-1:0]    phase;
  logic               wrap;
  logic               pend_valid;
  logic               wr_ok;
  logic               wr_bad;
  logic               wr_clr;
  logic [NUM_DOM-1:0] stb;

  ratio_phase_ctr #(.W(PH_W)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase),
    .wrap  (wrap)
  );

  ratio_cfg_ctrl #(.W(CFG_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_cfg     (wr_data[CFG_W-1:0]),
    .wr_clr_bit (wr_data[CLR_BIT]),
    .wrap       (wrap),
    .active_cfg (active_cfg),
    .err_flag   (err_flag),
    .pend_valid (pend_valid),
    .wr_ok      (wr_ok),
    .wr_bad     (wr_bad),
    .wr_clr     (wr_clr)
  );

  ratio_strobe_gen #(.N(NUM_DOM)) u_stb (
    .phase (phase),
    .cfg   (active_cfg),
    .stb   (stb)
  );

  assign core_stb = stb[D_CORE];
  assign bus_stb  = stb[D_BUS];
  assign per_stb  = stb[D_PER];
  assign tmr_stb  = stb[D_TMR];
  assign ckout_en = bus_stb;
endmodule

// File: rtl/clk_ratio_gen_chk.sv
module clk_ratio_gen_chk
  import clk_ratio_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wrap,
  input logic             pend_valid,
  input logic             wr_bad,
  input logic             wr_clr,
  input logic             core_stb,
  input logic             bus_stb,
  input logic             per_stb,
  input logic             tmr_stb,
  input logic             ckout_en,
  input logic [CFG_W-1:0] active_cfg,
  input logic             err_flag
);
  AST_WRAP_ALL_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (core_stb && bus_stb && per_stb && tmr_stb)); // R3
  AST_BUS_PER_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stb == per_stb); // R4
  AST_TMR_NOT_SLOWER: assert property (@(posedge clk) disable iff (!rst_n)
    per_stb |-> tmr_stb); // R5
  AST_CORE_NOT_SLOWER: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stb |-> core_stb); // R6
  AST_NO_RSV_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_cfg[1:0] != 2'b11) && (active_cfg[3:2] != 2'b11) &&
    (active_cfg[5:4] != 2'b11) && (active_cfg[7:6] != 2'b11)); // R7
  AST_BAD_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> err_flag); // R8
  AST_BAD_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bad && !(wrap && pend_valid)) |=> $stable(active_cfg)); // R8
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !wr_bad) |=> !err_flag); // R9
  AST_CFG_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(active_cfg)); // R10
  AST_SLOW_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_cfg[3:2] == 2'b10 && bus_stb) |=> !bus_stb); // R2
  AST_CKOUT_IMPLIES_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    ckout_en |-> (core_stb && per_stb)); // R11
endmodule

bind clk_ratio_gen clk_ratio_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wrap       (wrap),
  .pend_valid (pend_valid),
  .wr_bad     (wr_bad),
  .wr_clr     (wr_clr),
  .core_stb   (core_stb),
  .bus_stb    (bus_stb),
  .per_stb    (per_stb),
  .tmr_stb    (tmr_stb),
  .ckout_en   (ckout_en),
  .active_cfg (active_cfg),
  .err_flag   (err_flag)
);

// File: tb/clk_ratio_gen_bench.sv
module clk_ratio_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic       core_stb, bus_stb, per_stb, tmr_stb, ckout_en, err_flag;
  logic [7:0] active_cfg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [2:0] ph;
  logic [7:0] exp_cfg;

  always #4 clk = ~clk;

  clk_ratio_gen u_clk_ratio_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .core_stb(core_stb), .bus_stb(bus_stb), .per_stb(per_stb), .tmr_stb(tmr_stb),
    .ckout_en(ckout_en), .active_cfg(active_cfg), .err_flag(err_flag)
  );

  // phase = clock edges since reset released, modulo 8 (R2)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= 3'd0;
    else        ph <= ph + 3'd1;
  end

  // [12:9] requirement tag, [8] expected legal, [7:0] ratio fields
  localparam logic [12:0] VECS [10] = '{
    {4'd2, 1'b1, 8'h00},   // R2 all /2
    {4'd2, 1'b1, 8'h54},   // R2 core /2, rest /4
    {4'd2, 1'b1, 8'h15},   // R2 timer /2, rest /4
    {4'd4, 1'b0, 8'h59},   // R4 bus differs from peripheral
    {4'd5, 1'b0, 8'h95},   // R5 timer slower than peripheral
    {4'd6, 1'b0, 8'h56},   // R6 core slower than bus
    {4'd7, 1'b0, 8'h3C},   // R7 reserved code only
    {4'd2, 1'b1, 8'hAA},   // R2 all /8
    {4'd2, 1'b1, 8'h28},   // R2 core and timer /2, bus/per /8
    {4'd2, 1'b1, 8'h69}    // R2 core and timer /4, bus/per /8
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic hit(input logic [1:0] c, input logic [2:0] p);
    int period;
    if (c == 2'b11) return 1'b0;
    period = 2 << c;
    return ((int'(p) + 1) % period) == 0;
  endfunction

  task automatic chk_frame(input logic [7:0] cfg, input string req);
    for (int i = 0; i < 8; i++) begin
      logic [3:0] e;
      @(negedge clk);
      e = {hit(cfg[7:6], ph), hit(cfg[5:4], ph), hit(cfg[3:2], ph), hit(cfg[1:0], ph)};
      chk({tmr_stb, per_stb, bus_stb, core_stb} == e, req,
          {tmr_stb, per_stb, bus_stb, core_stb}, e);
      chk(ckout_en == e[1], "R11", ckout_en, e[1]);
    end
  endtask

  task automatic do_write(input logic [8:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic wait_apply(input logic [7:0] old_cfg);
    while (ph != 3'd7) @(negedge clk);
    chk(active_cfg == old_cfg, "R10", active_cfg, old_cfg);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(active_cfg == 8'hAA, "R1", active_cfg, 8'hAA);
    chk(err_flag == 1'b0, "R1", err_flag, 0);
    chk({tmr_stb, per_stb, bus_stb, core_stb} == 4'b0, "R1",
        {tmr_stb, per_stb, bus_stb, core_stb}, 0);
    rst_n = 1'b1;
    exp_cfg = 8'hAA;
    chk_frame(exp_cfg, "R3");

    foreach (VECS[k]) begin
      logic [7:0] old_cfg;
      logic       ok;
      string      tag;
      old_cfg = exp_cfg;
      ok  = VECS[k][8];
      tag = $sformatf("R%0d", VECS[k][12:9]);
      do_write({1'b1, VECS[k][7:0]});
      chk(err_flag == !ok, ok ? "R9" : "R8", err_flag, !ok);
      wait_apply(old_cfg);
      if (ok) exp_cfg = VECS[k][7:0];
      chk(active_cfg == exp_cfg, tag, active_cfg, exp_cfg);
      chk_frame(exp_cfg, tag);
    end

    // R8: refused write is sticky and keeps the setting
    do_write(9'h059);
    chk(err_flag == 1'b1, "R8", err_flag, 1);
    wait_apply(exp_cfg);
    chk(active_cfg == exp_cfg, "R8", active_cfg, exp_cfg);
    do_write(9'h0AA);
    chk(err_flag == 1'b1, "R8", err_flag, 1);
    // R9: clear, then clear with a refused write (set wins)
    do_write(9'h1AA);
    chk(err_flag == 1'b0, "R9", err_flag, 0);
    do_write(9'h159);
    chk(err_flag == 1'b1, "R9", err_flag, 1);
    do_write(9'h1AA);
    chk(err_flag == 1'b0, "R9", err_flag, 0);
    wait_apply(exp_cfg);
    exp_cfg = 8'hAA;
    chk(active_cfg == exp_cfg, "R10", active_cfg, exp_cfg);

    // R12: second pending write replaces the first
    while (ph != 3'd0) @(negedge clk);
    do_write(9'h100);
    do_write(9'h154);
    wait_apply(exp_cfg);
    exp_cfg = 8'h54;
    chk(active_cfg == exp_cfg, "R12", active_cfg, exp_cfg);
    chk_frame(exp_cfg, "R12");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule